// File: doc/BRIEF.md
# Flow-Controlled Serial Host Port

This block is the byte-asynchronous host-side port of a modem controller. The host sends characters into the block on a serial input line, and the block sends characters back to the host on a serial output line. Every character travels in one frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit, and a high stop bit. The bit rate comes from a static divider input. Parity enable and parity sense are also static configuration inputs.

The port regulates traffic in both directions. The host holds back the block's transmitter with a hold input. The hold is only checked between characters, so a character that has already started is always finished. In the other direction, the block raises a stop request toward the host early enough that three more characters still fit in its receive buffer.

Each received character is tagged by a level-sensitive mode input. A high level tags it as a command and a low level tags it as transparent data. Bytes pass to and from the internal link logic over small valid/ready byte interfaces.

Top module: `hostport_uart`

## Requirements
- R1: Frames on both lines are a low start bit, eight data bits sent least significant bit first, a parity bit only when `cfg_par_en` is 1, and a high stop bit. The parity bit is the XOR of the data bits when `cfg_par_odd` is 0 (even parity) and its inverse when `cfg_par_odd` is 1. Each bit lasts 16 × `cfg_div` clock cycles.
- R2: While `rst` is high at a clock edge, the following happen: both FIFOs empty, `cts_stop` goes low, `ser_out` goes high (idle), `rx_valid` goes low, and both error flags clear.
- R3: A new character starts on `ser_out` only while `rts_hold` is low. If `rts_hold` rises during a character, that character completes, and no further character starts until `rts_hold` is low again.
- R4: `cts_stop` is high whenever the receive FIFO (depth `RX_DEPTH`, default 8) holds `RX_DEPTH`−3 or more characters. The three characters that arrive after it rises are therefore still stored and delivered.
- R5: `rx_cmd` of each stored character equals the `cmd_mode` level at the time its stop bit is accepted: 1 means command, 0 means transparent data.
- R6: A low pulse on `ser_in` shorter than half a bit is not taken as a start bit. It stores nothing and sets no flag.
- R7: If the stop bit is sampled low, the character is discarded and the sticky `frame_err` flag is set.
- R8: With parity enabled, a character whose parity bit does not match is discarded and the sticky `par_err` flag is set. Matching characters are stored normally.
- R9: Bytes written through `tx_valid`/`tx_ready` enter a transmit FIFO of `TX_DEPTH` (default 4) entries and are sent in the order written. `tx_ready` is low while that FIFO is full.
- R10: Stored characters leave on `rx_valid`/`rx_ready` in the order received, one per cycle in which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Clock cycles per 1/16 bit (0 treated as 1) |
| cfg_par_en | input | 1 | 1 adds a parity bit to every frame |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cmd_mode | input | 1 | 1 tags received characters as commands, 0 as data |
| ser_in | input | 1 | Serial line from the host |
| ser_out | output | 1 | Serial line to the host, idle high |
| rts_hold | input | 1 | High holds off new characters on `ser_out` |
| cts_stop | output | 1 | High asks the host to stop sending |
| tx_valid | input | 1 | Link side offers a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmit FIFO can take a byte |
| rx_valid | output | 1 | A received character is available |
| rx_data | output | 8 | Received character |
| rx_cmd | output | 1 | Tag of the received character |
| rx_ready | input | 1 | Link side takes the character |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |
| par_err | output | 1 | Sticky: a parity mismatch was seen |

## Verification
Two events can fall in the same cycle. One is the link side writing a byte into the transmit FIFO. The other is the serializer pulling a byte out of that FIFO.

The bench provokes this by streaming six bytes with `tx_valid` held high into an idle port. The second write then lands in the cycle in which the serializer takes the first byte, and later writes wait on a full FIFO.

The bench decodes `ser_out` independently and compares every character against its own queue. A byte that is lost or doubled in that cycle appears as a mismatch. The bench also requires that `tx_ready` was seen low.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int          DATA_W  = 8;
    localparam logic [3:0]  HALF_T  = 4'd7;
    localparam logic [3:0]  LAST_T  = 4'd15;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

    typedef struct packed {
        logic              cmd;
        logic [DATA_W-1:0] data;
    } rx_item_t;

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/hp_tick.sv
module hp_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  logic [WIDTH-1:0]       wdata,
    input  logic                   pop,
    output logic [WIDTH-1:0]       rdata,
    output logic                   full,
    output logic                   empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hp_rx.sv
module hp_rx
    import hp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  logic     par_en,
    input  logic     par_odd,
    input  logic     cmd_mode,
    output logic     wr_en,
    output rx_item_t wr_item,
    output logic     frame_err,
    output logic     par_err
);
    rx_state_t         st;
    logic [3:0]        tcnt, bidx, last_idx;
    logic [DATA_W:0]   shreg;
    logic [DATA_W-1:0] data_w;

    assign last_idx = par_en ? 4'd8 : 4'd7;
    assign data_w   = par_en ? shreg[DATA_W-1:0] : shreg[DATA_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            wr_en     <= 1'b0;
            wr_item   <= '0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (!line) begin
                            st   <= RX_START;
                            tcnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == HALF_T) begin
                            st   <= line ? RX_IDLE : RX_BITS;
                            tcnt <= '0;
                            bidx <= '0;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (tcnt == LAST_T) begin
                            shreg <= {line, shreg[DATA_W:1]};
                            tcnt  <= '0;
                            bidx  <= bidx + 1'b1;
                            if (bidx == last_idx) st <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == LAST_T) begin
                            st   <= RX_IDLE;
                            tcnt <= '0;
                            if (!line) begin
                                frame_err <= 1'b1;
                            end else if (par_en && (shreg[DATA_W] != par_bit(data_w, par_odd))) begin
                                par_err <= 1'b1;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_item <= '{cmd: cmd_mode, data: data_w};
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/hp_tx.sv
module hp_tx
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] data,
    input  logic              rts_hold,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    logic [DATA_W+2:0] shreg;
    logic [3:0]        tcnt, bidx, last_idx;

    assign pop  = !busy && avail && !rts_hold;
    assign line = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            shreg    <= '1;
            tcnt     <= '0;
            bidx     <= '0;
            last_idx <= '0;
        end else if (pop) begin
            busy     <= 1'b1;
            shreg    <= {1'b1, (par_en ? par_bit(data, par_odd) : 1'b1), data, 1'b0};
            last_idx <= par_en ? 4'd10 : 4'd9;
            tcnt     <= '0;
            bidx     <= '0;
        end else if (busy && tick) begin
            if (tcnt == LAST_T) begin
                shreg <= {1'b1, shreg[DATA_W+2:1]};
                tcnt  <= '0;
                if (bidx == last_idx) busy <= 1'b0;
                else                  bidx <= bidx + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hostport_uart.sv
module hostport_uart
    import hp_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 4,
    parameter int CTS_ROOM = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cmd_mode,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic             rts_hold,
    output logic             cts_stop,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_cmd,
    input  logic             rx_ready,
    output logic             frame_err,
    output logic             par_err
);
    localparam int RX_CW = $clog2(RX_DEPTH) + 1;
    localparam int TX_CW = $clog2(TX_DEPTH) + 1;
    localparam int ITEM_W = $bits(rx_item_t);

    logic [1:0]        in_sync;
    logic              tick;
    logic              rx_wr;
    rx_item_t          rx_witem, rx_ritem;
    logic              rx_full, rx_empty;
    logic [RX_CW-1:0]  rx_count;
    logic              tx_full, tx_empty, tx_pop, tx_busy;
    logic [7:0]        tx_head;
    logic [TX_CW-1:0]  tx_count;

    always_ff @(posedge clk) begin
        if (rst) in_sync <= 2'b11;
        else     in_sync <= {in_sync[0], ser_in};
    end

    hp_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .tick(tick)
    );

    hp_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .line(in_sync[1]),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd), .cmd_mode(cmd_mode),
        .wr_en(rx_wr), .wr_item(rx_witem), .frame_err(frame_err), .par_err(par_err)
    );

    hp_fifo #(.WIDTH(ITEM_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_wr), .wdata(rx_witem), .pop(rx_ready),
        .rdata(rx_ritem), .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    assign rx_valid = !rx_empty;
    assign rx_data  = rx_ritem.data;
    assign rx_cmd   = rx_ritem.cmd;

    always_ff @(posedge clk) begin
        if (rst) cts_stop <= 1'b0;
        else     cts_stop <= (rx_count >= RX_CW'(RX_DEPTH - CTS_ROOM));
    end

    hp_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_valid), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    assign tx_ready = !tx_full;

    hp_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .avail(!tx_empty), .data(tx_head),
        .rts_hold(rts_hold), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .pop(tx_pop), .line(ser_out), .busy(tx_busy)
    );
endmodule

// File: rtl/hostport_uart_chk.sv
module hostport_uart_chk #(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 4,
    parameter int CTS_ROOM = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        ser_out,
    input logic                        rts_hold,
    input logic                        cts_stop,
    input logic                        rx_valid,
    input logic                        frame_err,
    input logic                        par_err,
    input logic                        tx_busy,
    input logic                        rx_full,
    input logic [$clog2(RX_DEPTH):0]   rx_count,
    input logic [$clog2(TX_DEPTH):0]   tx_count
);
    localparam int RCW = $clog2(RX_DEPTH) + 1;
    localparam int TCW = $clog2(TX_DEPTH) + 1;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!cts_stop && ser_out && !rx_valid && !frame_err && !par_err)); // R2
    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> ser_out); // R1
    AST_STOP_BEFORE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(ser_out)); // R1
    AST_START_PERMITTED: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !$past(rts_hold)); // R3
    AST_CTS_AT_ROOM: assert property (@(posedge clk) disable iff (rst)
        $rose(cts_stop) |-> ($past(rx_count) == RCW'(RX_DEPTH - CTS_ROOM))); // R4
    AST_FULL_HAS_CTS: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> cts_stop); // R4
    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err); // R7
    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (rst)
        par_err |=> par_err); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        tx_count <= TCW'(TX_DEPTH)); // R9
endmodule

bind hostport_uart hostport_uart_chk #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .CTS_ROOM(CTS_ROOM)
) u_chk (
    .clk(clk), .rst(rst), .ser_out(ser_out), .rts_hold(rts_hold),
    .cts_stop(cts_stop), .rx_valid(rx_valid), .frame_err(frame_err),
    .par_err(par_err), .tx_busy(tx_busy), .rx_full(rx_full),
    .rx_count(rx_count), .tx_count(tx_count)
);

// File: tb/hostport_uart_bench.sv
module hostport_uart_bench;
    localparam int DIV   = 4;
    localparam int BIT   = 16 * DIV;
    localparam int FRAME = 11 * BIT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_div = 16'(DIV);
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cmd_mode = 1'b0;
    logic        ser_in = 1'b1, rts_hold = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        ser_out, cts_stop, tx_ready, rx_valid, rx_cmd, frame_err, par_err;
    logic [7:0]  rx_data;

    int n_chk = 0, n_err = 0, got_tx = 0;
    bit finished = 0, saw_full = 0;
    logic [8:0] rx_model[$];
    logic [7:0] tx_model[$];

    always #10 clk = ~clk;

    hostport_uart u_hostport_uart (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cmd_mode(cmd_mode), .ser_in(ser_in),
        .ser_out(ser_out), .rts_hold(rts_hold), .cts_stop(cts_stop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_cmd(rx_cmd),
        .rx_ready(rx_ready), .frame_err(frame_err), .par_err(par_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        ser_in = b;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit bad_stop);
        bit good;
        good = !flip_par && !bad_stop;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (cfg_par_en) drive_bit(((^d) ^ cfg_par_odd) ^ flip_par);
        if (good) rx_model.push_back({cmd_mode, d});
        if (bad_stop) begin
            ser_in = 1'b0;
            repeat (10 * DIV) @(negedge clk);
            ser_in = 1'b1;
            repeat (6 * DIV) @(negedge clk);
        end else begin
            drive_bit(1'b1);
        end
        drive_bit(1'b1);
    endtask

    task automatic pop_check(input string req);
        logic [8:0] e;
        int w;
        w = 0;
        while (!rx_valid && w < 2000) begin
            @(negedge clk);
            w++;
        end
        e = (rx_model.size() > 0) ? rx_model.pop_front() : 9'h1ff;
        chk(rx_valid === 1'b1, req, "rx_valid", rx_valid, 1);
        chk(rx_data === e[7:0], req, "rx_data", rx_data, e[7:0]);
        chk(rx_cmd === e[8], req, "rx_cmd tag", rx_cmd, e[8]);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_model.push_back(d);
        tx_valid = 1'b1;
        tx_data  = d;
        while (!tx_ready) begin
            saw_full = 1;
            @(negedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_tx_drain();
        int w;
        w = 0;
        while ((tx_model.size() > 0 || ser_out !== 1'b1) && w < 20 * FRAME) begin
            @(negedge clk);
            w++;
        end
        repeat (BIT) @(negedge clk);
    endtask

    // independent decoder of the outgoing line
    initial begin : mon
        logic [7:0] b;
        logic       p;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (!rst && ser_out === 1'b0) begin
                repeat (BIT / 2) @(negedge clk);
                chk(ser_out === 1'b0, "R1", "tx start bit", ser_out, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    b[i] = ser_out;
                end
                if (cfg_par_en) begin
                    repeat (BIT) @(negedge clk);
                    p = ser_out;
                    chk(p === ((^b) ^ cfg_par_odd), "R1", "tx parity bit", p, (^b) ^ cfg_par_odd);
                end
                repeat (BIT) @(negedge clk);
                chk(ser_out === 1'b1, "R1", "tx stop bit", ser_out, 1);
                e = (tx_model.size() > 0) ? tx_model.pop_front() : 8'hxx;
                chk(b === e, "R9", "tx byte order", b, e);
                got_tx++;
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk(cts_stop === 1'b0, "R2", "cts after reset", cts_stop, 0);
        chk(ser_out === 1'b1, "R2", "ser_out idle", ser_out, 1);
        chk(rx_valid === 1'b0, "R2", "rx empty", rx_valid, 0);
        chk(tx_ready === 1'b1, "R2", "tx fifo empty", tx_ready, 1);
        chk(frame_err === 1'b0 && par_err === 1'b0, "R2", "flags clear", {frame_err, par_err}, 0);

        // R1 R5 R10: basic receive with both tags
        cmd_mode = 1'b1;
        send_frame(8'hA5, 0, 0);
        cmd_mode = 1'b0;
        send_frame(8'h3C, 0, 0);
        pop_check("R5");
        pop_check("R10");
        chk(rx_valid === 1'b0, "R10", "rx drained", rx_valid, 0);

        // R6: short glitch ignored
        ser_in = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        ser_in = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(rx_valid === 1'b0, "R6", "glitch stored nothing", rx_valid, 0);
        chk(frame_err === 1'b0, "R6", "glitch no flag", frame_err, 0);

        // R4: CTS with three bytes of room
        for (int i = 0; i < 8; i++) begin
            cmd_mode = i[0];
            send_frame(8'(i * 17 + 1), 0, 0);
            chk(cts_stop === (rx_model.size() >= 5), "R4", "cts level", cts_stop, rx_model.size() >= 5);
        end
        for (int i = 0; i < 8; i++) begin
            pop_check("R4");
            if (i == 3) begin
                @(negedge clk);
                chk(cts_stop === 1'b0, "R4", "cts falls with room", cts_stop, 0);
            end
        end

        // R7: framing error drops byte, sticky
        send_frame(8'h77, 0, 1);
        chk(frame_err === 1'b1, "R7", "frame_err set", frame_err, 1);
        chk(rx_valid === 1'b0, "R7", "bad frame dropped", rx_valid, 0);

        // R8: parity
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        send_frame(8'h5A, 0, 0);
        send_frame(8'h81, 1, 0);
        chk(par_err === 1'b1, "R8", "par_err set", par_err, 1);
        cfg_par_odd = 1'b1;
        send_frame(8'hC3, 0, 0);
        pop_check("R8");
        pop_check("R8");
        chk(rx_valid === 1'b0, "R8", "mismatch dropped", rx_valid, 0);
        chk(par_err === 1'b1 && frame_err === 1'b1, "R8", "flags sticky", {frame_err, par_err}, 3);

        // R9 R1: streamed transmit, parity off
        cfg_par_en = 1'b0;
        for (int i = 0; i < 6; i++) push_tx(8'(8'h10 + i * 8'h23));
        chk(saw_full == 1, "R9", "tx_ready low when full", saw_full, 1);
        wait_tx_drain();
        chk(got_tx == 6, "R9", "bytes sent", got_tx, 6);

        // R3: hold at byte boundary
        rts_hold = 1'b1;
        base = got_tx;
        push_tx(8'h11);
        push_tx(8'h22);
        push_tx(8'h33);
        repeat (3 * FRAME) @(negedge clk);
        chk(got_tx == base && ser_out === 1'b1, "R3", "held before start", got_tx - base, 0);
        rts_hold = 1'b0;
        while (ser_out !== 1'b0) @(negedge clk);
        repeat (2 * BIT) @(negedge clk);
        rts_hold = 1'b1;
        repeat (3 * FRAME) @(negedge clk);
        chk(got_tx == base + 1, "R3", "in-flight byte completed only", got_tx - base, 1);
        chk(ser_out === 1'b1, "R3", "idle while held", ser_out, 1);
        rts_hold = 1'b0;
        wait_tx_drain();
        chk(got_tx == base + 3, "R3", "rest sent after release", got_tx - base, 3);

        // R1: transmit with odd parity
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b1;
        push_tx(8'hE7);
        push_tx(8'h01);
        wait_tx_drain();
        chk(got_tx == base + 5, "R1", "parity frames sent", got_tx - base, 5);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule